// File: doc/BRIEF.md
# Receive Framing Error Detector

This block watches the receive side of a multi-lane serial link that carries 130-bit blocks, after lane deskew and descrambling. For every block it is given the 2-bit sync header of each lane, and between headers it is given the packet-level byte stream one byte per cycle. It finds packet boundaries from the packet contents alone: a transaction packet carries its own length (in doublewords) with check bits, a link-layer packet is always 8 bytes, and idle, end-of-stream marker and end-bad bytes take one byte each. No end symbol exists, so the byte that follows a transaction packet decides whether that packet ended normally or is to be discarded.

Each header and each boundary byte is checked. On the first violation the block raises a one-cycle error pulse, latches a cause code, holds a recovery request to the link training state machine and stops delivering and checking packets. A recovery-done input clears the error. Checking and delivery resume only when block lock is acquired on an electrical-idle-exit ordered set, which also restarts boundary tracking. Valid packet bytes are passed on one cycle later with a start-of-packet flag.

Top module: `rx_frame_err_det`

## Requirements
- R1: A sync header value other than 01b (data block) or 10b (ordered-set block) on any lane raises an error with cause 1.
- R2: When every lane holds a legal value but the lanes do not all agree, an error with cause 2 is raised.
- R3: At a packet boundary the byte must be a transaction start (bits 3:0 = 1111b), a link-layer start F0h, an idle 00h, an end-of-stream marker E0h, or (see R8) an end-bad byte C0h; any other byte raises an error with cause 3. Idle bytes are accepted and skipped.
- R4: A transaction header is byte0 = {len[3:0], 1111b}, byte1 = {P, len[10:4]}, byte2 = {chk[3:0], seq[11:8]}, where chk is the remainder of len(x)·x^4 divided by x^4+x+1 (len bit 10 highest) and P is the XOR of all length and check bits. A wrong chk, a wrong P, or a length outside 5..1031 doublewords raises an error with cause 4 when byte2 arrives; byte2 is then not delivered.
- R5: The next boundary lies len·4 bytes after a transaction start and 8 bytes after a link-layer start; packets may span data-block headers.
- R6: An ordered-set header that follows a data block in which no end-of-stream marker was seen raises an error with cause 5.
- R7: After an end-of-stream marker the rest of the data block is not parsed, the next header must be 10b on all lanes (else an error with cause 6), and the next data block starts at a packet boundary.
- R8: An end-bad byte C0h at the boundary directly after a transaction packet produces a one-cycle nullify pulse and no error; anywhere else it raises an error with cause 3.
- R9: The error pulse is high for exactly one cycle, in the cycle after the offending input; the cause of the first error is held, and the recovery request stays high, until recovery-done, which clears both.
- R10: While the recovery request is high no byte is delivered and no further check runs; an electrical-idle-exit lock indication during that time is ignored, so delivery resumes only on a lock indication after recovery-done.
- R11: Bytes of transaction and link-layer packets appear on the output one cycle after input, with the start flag on their first byte; idle, marker and end-bad bytes are not delivered.
- R12: After reset the block is not armed: no error is flagged, nothing is delivered and headers and bytes are not checked until the first electrical-idle-exit lock indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_vld | input | 1 | Sync headers of a new block are present (takes precedence over byte_vld) |
| sync_hdr | input | 2*LANES | Sync header of each lane, lane i in bits 2i+1:2i |
| byte_vld | input | 1 | A packet-level byte is present |
| byte_in | input | 8 | Packet-level byte |
| eieos_lock | input | 1 | Block lock acquired on an electrical-idle-exit ordered set |
| recov_done | input | 1 | Link recovery has completed |
| out_vld | output | 1 | Delivered packet byte valid |
| out_sop | output | 1 | Delivered byte is the first of its packet |
| out_byte | output | 8 | Delivered packet byte |
| out_nullify | output | 1 | Previous transaction packet ended with an end-bad byte |
| err_pulse | output | 1 | One-cycle framing error indication |
| err_cause | output | 3 | Latched cause of the first error, 0 when none |
| recov_req | output | 1 | Request to enter recovery |

## Verification
A long random stream of well-formed transaction packets of varied length, link-layer packets, idles, end-bad bytes and marker/ordered-set/data header sequences, with data headers dropped in mid-packet, must be delivered byte for byte with no error; this separates correct boundary arithmetic from an off-by-one or a lost straddle. Headers with a single flipped bit in the length, check or parity field must each give cause 4, showing the check bits are really compared. Directed cases hit one rule each (illegal header value, lane disagreement, bad start byte, end-bad in the wrong place, missing marker, marker followed by a data block, lengths 4, 1031 and 1032), and the error sequence checks that the first cause is held, that a lock indication during an error is ignored, and that nothing flows until re-arming.

// File: rtl/rx_fe_pkg.sv
package rx_fe_pkg;

    localparam logic [1:0] SYNC_DATA = 2'b01;
    localparam logic [1:0] SYNC_OSET = 2'b10;

    localparam logic [7:0] TOK_DLLP = 8'hF0;
    localparam logic [7:0] TOK_IDLE = 8'h00;
    localparam logic [7:0] TOK_MARK = 8'hE0;
    localparam logic [7:0] TOK_NULL = 8'hC0;
    localparam logic [3:0] TLP_NIB  = 4'hF;

    localparam int LEN_W      = 11;
    localparam int CHK_W      = 4;
    localparam int DLLP_BYTES = 8;

    typedef enum logic [2:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_SYNC_VAL  = 3'd1,
        CAUSE_SYNC_LANE = 3'd2,
        CAUSE_START     = 3'd3,
        CAUSE_LEN       = 3'd4,
        CAUSE_NO_MARK   = 3'd5,
        CAUSE_MARK_SEQ  = 3'd6
    } cause_e;

    typedef enum logic [2:0] {
        TRK_BOUND,
        TRK_HDR1,
        TRK_HDR2,
        TRK_BODY,
        TRK_HALT
    } trk_e;

    typedef struct packed {
        logic   hit;
        cause_e cause;
    } fault_t;

    // remainder of len(x)*x^4 modulo x^4 + x + 1, shifted in MSB first
    function automatic logic [CHK_W-1:0] len_chk(input logic [LEN_W-1:0] len);
        logic [CHK_W-1:0] r;
        logic             fb;
        r = '0;
        for (int i = LEN_W - 1; i >= 0; i--) begin
            fb = r[CHK_W-1] ^ len[i];
            r  = {r[CHK_W-2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
        end
        return r;
    endfunction

endpackage

// File: rtl/rx_fe_sync_check.sv
module rx_fe_sync_check
    import rx_fe_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [2*LANES-1:0] sync_hdr,
    output logic               any_bad,
    output logic               disagree,
    output logic [1:0]         kind
);
    logic [LANES-1:0] lane_bad;
    logic [LANES-1:0] lane_diff;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_bad[i]  = !((sync_hdr[2*i +: 2] == SYNC_DATA) ||
                                (sync_hdr[2*i +: 2] == SYNC_OSET));
        assign lane_diff[i] = sync_hdr[2*i +: 2] != sync_hdr[1:0];
    end

    assign any_bad  = |lane_bad;
    assign disagree = |lane_diff;
    assign kind     = sync_hdr[1:0];
endmodule

// File: rtl/rx_fe_len_check.sv
module rx_fe_len_check
    import rx_fe_pkg::*;
#(
    parameter int MIN_LEN_DW = 5,
    parameter int MAX_LEN_DW = 1031
) (
    input  logic [7:0]       b0,
    input  logic [7:0]       b1,
    input  logic [7:0]       b2,
    output logic             ok,
    output logic [LEN_W-1:0] len_dw
);
    logic [CHK_W-1:0] chk_rx;
    logic             par_rx;
    logic             chk_good;
    logic             par_good;
    logic             range_good;

    assign len_dw     = {b1[6:0], b0[7:4]};
    assign chk_rx     = b2[7:4];
    assign par_rx     = b1[7];
    assign chk_good   = chk_rx == len_chk(len_dw);
    assign par_good   = par_rx == ^{len_dw, chk_rx};
    assign range_good = (len_dw >= LEN_W'(MIN_LEN_DW)) && (len_dw <= LEN_W'(MAX_LEN_DW));
    assign ok         = chk_good && par_good && range_good;
endmodule

// File: rtl/rx_fe_tracker.sv
module rx_fe_tracker
    import rx_fe_pkg::*;
#(
    parameter int MIN_LEN_DW = 5,
    parameter int MAX_LEN_DW = 1031
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       en,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    output fault_t     fault,
    output logic       mark_hit,
    output logic       out_vld,
    output logic       out_sop,
    output logic [7:0] out_byte,
    output logic       out_nullify
);
    localparam int CNT_W = $clog2(MAX_LEN_DW * 4 + 1);

    trk_e             st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [7:0]       b0_q, b1_q;
    logic             tlp_q, tlp_d;
    logic             after_tlp_q, after_tlp_d;
    logic             deliver, sop, nullify;
    logic             hdr_ok;
    logic [LEN_W-1:0] len_dw;
    logic             take;

    rx_fe_len_check #(
        .MIN_LEN_DW(MIN_LEN_DW),
        .MAX_LEN_DW(MAX_LEN_DW)
    ) u_len (
        .b0    (b0_q),
        .b1    (b1_q),
        .b2    (byte_in),
        .ok    (hdr_ok),
        .len_dw(len_dw)
    );

    assign take = en && byte_vld;

    always_comb begin
        st_d        = st_q;
        cnt_d       = cnt_q;
        tlp_d       = tlp_q;
        after_tlp_d = after_tlp_q;
        fault       = '{hit: 1'b0, cause: CAUSE_NONE};
        mark_hit    = 1'b0;
        deliver     = 1'b0;
        sop         = 1'b0;
        nullify     = 1'b0;
        if (take) begin
            unique case (st_q)
                TRK_BOUND: begin
                    after_tlp_d = 1'b0;
                    if (byte_in[3:0] == TLP_NIB) begin
                        deliver = 1'b1;
                        sop     = 1'b1;
                        tlp_d   = 1'b1;
                        st_d    = TRK_HDR1;
                    end else if (byte_in == TOK_DLLP) begin
                        deliver = 1'b1;
                        sop     = 1'b1;
                        tlp_d   = 1'b0;
                        cnt_d   = CNT_W'(DLLP_BYTES - 1);
                        st_d    = TRK_BODY;
                    end else if (byte_in == TOK_IDLE) begin
                        st_d = TRK_BOUND;
                    end else if (byte_in == TOK_MARK) begin
                        mark_hit = 1'b1;
                        st_d     = TRK_HALT;
                    end else if (byte_in == TOK_NULL && after_tlp_q) begin
                        nullify = 1'b1;
                    end else begin
                        fault = '{hit: 1'b1, cause: CAUSE_START};
                    end
                end
                TRK_HDR1: begin
                    deliver = 1'b1;
                    st_d    = TRK_HDR2;
                end
                TRK_HDR2: begin
                    if (!hdr_ok) begin
                        fault = '{hit: 1'b1, cause: CAUSE_LEN};
                    end else begin
                        deliver = 1'b1;
                        cnt_d   = CNT_W'({len_dw, 2'b00}) - CNT_W'(3);
                        st_d    = TRK_BODY;
                    end
                end
                TRK_BODY: begin
                    deliver = 1'b1;
                    cnt_d   = cnt_q - CNT_W'(1);
                    if (cnt_q == CNT_W'(1)) begin
                        st_d        = TRK_BOUND;
                        after_tlp_d = tlp_q;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            st_q        <= TRK_BOUND;
            cnt_q       <= '0;
            tlp_q       <= 1'b0;
            after_tlp_q <= 1'b0;
            b0_q        <= '0;
            b1_q        <= '0;
            out_vld     <= 1'b0;
            out_sop     <= 1'b0;
            out_byte    <= '0;
            out_nullify <= 1'b0;
        end else begin
            st_q        <= st_d;
            cnt_q       <= cnt_d;
            tlp_q       <= tlp_d;
            after_tlp_q <= after_tlp_d;
            if (take && st_q == TRK_BOUND) b0_q <= byte_in;
            if (take && st_q == TRK_HDR1)  b1_q <= byte_in;
            out_vld     <= deliver;
            out_sop     <= sop;
            out_byte    <= byte_in;
            out_nullify <= nullify;
        end
    end
endmodule

// File: rtl/rx_fe_err_ctrl.sv
module rx_fe_err_ctrl
    import rx_fe_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  fault_t fault_in,
    input  logic   recov_done,
    output logic   err_pulse,
    output cause_e err_cause,
    output logic   recov_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_pulse <= 1'b0;
            err_cause <= CAUSE_NONE;
            recov_req <= 1'b0;
        end else begin
            err_pulse <= 1'b0;
            if (recov_done) begin
                err_cause <= CAUSE_NONE;
                recov_req <= 1'b0;
            end else if (fault_in.hit && !recov_req) begin
                err_pulse <= 1'b1;
                err_cause <= fault_in.cause;
                recov_req <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rx_frame_err_det.sv
module rx_frame_err_det
    import rx_fe_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int MIN_LEN_DW = 5,
    parameter int MAX_LEN_DW = 1031
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sync_vld,
    input  logic [2*LANES-1:0] sync_hdr,
    input  logic               byte_vld,
    input  logic [7:0]         byte_in,
    input  logic               eieos_lock,
    input  logic               recov_done,
    output logic               out_vld,
    output logic               out_sop,
    output logic [7:0]         out_byte,
    output logic               out_nullify,
    output logic               err_pulse,
    output logic [2:0]         err_cause,
    output logic               recov_req
);
    logic   armed_q, in_data_q, prev_data_q, mark_q;
    logic   any_bad, disagree;
    logic [1:0] kind;
    fault_t sync_fault, trk_fault, fault_sel, fault_eff;
    logic   live, trk_en, trk_restart, trk_mark, rearm;
    cause_e cause_q;

    rx_fe_sync_check #(.LANES(LANES)) u_sync (
        .sync_hdr(sync_hdr),
        .any_bad (any_bad),
        .disagree(disagree),
        .kind    (kind)
    );

    always_comb begin
        sync_fault = '{hit: 1'b0, cause: CAUSE_NONE};
        if (any_bad)
            sync_fault = '{hit: 1'b1, cause: CAUSE_SYNC_VAL};
        else if (disagree)
            sync_fault = '{hit: 1'b1, cause: CAUSE_SYNC_LANE};
        else if (kind == SYNC_OSET && prev_data_q && !mark_q)
            sync_fault = '{hit: 1'b1, cause: CAUSE_NO_MARK};
        else if (kind == SYNC_DATA && mark_q)
            sync_fault = '{hit: 1'b1, cause: CAUSE_MARK_SEQ};
    end

    assign live        = armed_q && !recov_req;
    assign rearm       = eieos_lock && !recov_req;
    assign trk_en      = live && in_data_q && !sync_vld;
    assign trk_restart = rearm || (live && sync_vld && !sync_fault.hit && kind == SYNC_OSET);
    assign fault_sel   = sync_vld ? sync_fault : trk_fault;
    assign fault_eff   = '{hit: live && fault_sel.hit, cause: fault_sel.cause};

    rx_fe_tracker #(
        .MIN_LEN_DW(MIN_LEN_DW),
        .MAX_LEN_DW(MAX_LEN_DW)
    ) u_trk (
        .clk        (clk),
        .rst        (rst),
        .restart    (trk_restart),
        .en         (trk_en),
        .byte_vld   (byte_vld),
        .byte_in    (byte_in),
        .fault      (trk_fault),
        .mark_hit   (trk_mark),
        .out_vld    (out_vld),
        .out_sop    (out_sop),
        .out_byte   (out_byte),
        .out_nullify(out_nullify)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q     <= 1'b0;
            in_data_q   <= 1'b0;
            prev_data_q <= 1'b0;
            mark_q      <= 1'b0;
        end else if (fault_eff.hit) begin
            armed_q <= 1'b0;
        end else if (rearm) begin
            armed_q     <= 1'b1;
            in_data_q   <= 1'b0;
            prev_data_q <= 1'b0;
            mark_q      <= 1'b0;
        end else if (live && sync_vld) begin
            in_data_q   <= kind == SYNC_DATA;
            prev_data_q <= kind == SYNC_DATA;
            mark_q      <= 1'b0;
        end else if (trk_mark) begin
            mark_q <= 1'b1;
        end
    end

    rx_fe_err_ctrl u_err (
        .clk       (clk),
        .rst       (rst),
        .fault_in  (fault_eff),
        .recov_done(recov_done),
        .err_pulse (err_pulse),
        .err_cause (cause_q),
        .recov_req (recov_req)
    );

    assign err_cause = cause_q;
endmodule

// File: rtl/rx_frame_err_det_chk.sv
module rx_frame_err_det_chk #(
    parameter int LANES = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               sync_vld,
    input logic [2*LANES-1:0] sync_hdr,
    input logic               armed_q,
    input logic               out_vld,
    input logic               out_sop,
    input logic               out_nullify,
    input logic               err_pulse,
    input logic [2:0]         err_cause,
    input logic               recov_req,
    input logic               recov_done
);
    logic hdr_illegal;

    always_comb begin
        hdr_illegal = 1'b0;
        for (int i = 0; i < LANES; i++)
            if (sync_hdr[2*i +: 2] == 2'b00 || sync_hdr[2*i +: 2] == 2'b11)
                hdr_illegal = 1'b1;
    end

    a_r1_illegal_hdr: assert property (@(posedge clk) disable iff (rst)
        (sync_vld && armed_q && !recov_req && hdr_illegal) |=> (err_pulse && err_cause == 3'd1));

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> !err_pulse);

    a_r9_pulse_has_cause: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (recov_req && err_cause != 3'd0));

    a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
        (recov_req && !recov_done) |=> (recov_req && $stable(err_cause)));

    a_r10_no_delivery: assert property (@(posedge clk) disable iff (rst)
        recov_req |-> !out_vld);

    a_r11_sop_valid: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> out_vld);

    a_r8_nullify_clean: assert property (@(posedge clk) disable iff (rst)
        out_nullify |-> (!err_pulse && !out_vld));
endmodule

bind rx_frame_err_det rx_frame_err_det_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sync_vld   (sync_vld),
    .sync_hdr   (sync_hdr),
    .armed_q    (armed_q),
    .out_vld    (out_vld),
    .out_sop    (out_sop),
    .out_nullify(out_nullify),
    .err_pulse  (err_pulse),
    .err_cause  (err_cause),
    .recov_req  (recov_req),
    .recov_done (recov_done)
);

// File: tb/tb_rx_frame_err_det.sv
module tb_rx_frame_err_det;
    localparam int LANES = 4;
    localparam logic [7:0] HDR_DATA = 8'h55;
    localparam logic [7:0] HDR_OS   = 8'hAA;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_vld = 1'b0;
    logic [7:0] sync_hdr = '0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = '0;
    logic       eieos_lock = 1'b0;
    logic       recov_done = 1'b0;
    logic       out_vld, out_sop, out_nullify, err_pulse, recov_req;
    logic [7:0] out_byte;
    logic [2:0] err_cause;

    always #10 clk = ~clk;

    rx_frame_err_det #(.LANES(LANES)) dut (
        .clk(clk), .rst(rst), .sync_vld(sync_vld), .sync_hdr(sync_hdr),
        .byte_vld(byte_vld), .byte_in(byte_in), .eieos_lock(eieos_lock),
        .recov_done(recov_done), .out_vld(out_vld), .out_sop(out_sop),
        .out_byte(out_byte), .out_nullify(out_nullify), .err_pulse(err_pulse),
        .err_cause(err_cause), .recov_req(recov_req)
    );

    int  checks = 0, errors = 0;
    int  dcnt = 0, dsum = 0, scnt = 0, ncnt = 0;
    int  exp_d = 0, exp_sum = 0, exp_sop = 0, exp_null = 0;
    bit  rnd_sync = 0;
    bit  done = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_vld) begin
                dcnt++;
                dsum += int'(out_byte);
                if (out_sop) scnt++;
            end
            if (out_nullify) ncnt++;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_chk(input logic [10:0] len);
        logic [14:0] v;
        v = {len, 4'b0000};
        for (int i = 14; i >= 4; i--)
            if (v[i]) v = v ^ (15'b10011 << (i - 4));
        return v[3:0];
    endfunction

    task automatic send_sync(input logic [7:0] h);
        sync_vld = 1'b1; sync_hdr = h;
        @(negedge clk);
        sync_vld = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_vld = 1'b1; byte_in = b;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic put(input logic [7:0] b, input bit del);
        if (rnd_sync && ($urandom % 32) == 0) send_sync(HDR_DATA);
        send_byte(b);
        if (del) begin exp_d++; exp_sum += int'(b); end
    endtask

    task automatic pulse_eieos();
        eieos_lock = 1'b1; @(negedge clk); eieos_lock = 1'b0;
    endtask

    task automatic pulse_recov();
        recov_done = 1'b1; @(negedge clk); recov_done = 1'b0;
    endtask

    task automatic rearm();
        pulse_recov(); pulse_eieos(); send_sync(HDR_DATA);
    endtask

    // flip: -1 none, 0..7 bit of byte1, 8..11 check bit in byte2
    task automatic send_tlp(input int len, input int flip, input bit del, input bit stop);
        logic [10:0] l;
        logic [3:0]  c;
        logic [7:0]  b;
        l = 11'(len);
        c = ref_chk(l);
        if (del) exp_sop++;
        for (int i = 0; i < (stop ? 3 : len * 4); i++) begin
            case (i)
                0: b = {l[3:0], 4'hF};
                1: b = {^{l, c}, l[10:4]};
                2: b = {c, 4'h3};
                3: b = 8'h5A;
                default: b = 8'($urandom);
            endcase
            if (flip >= 0 && flip < 8 && i == 1) b[flip] = ~b[flip];
            if (flip >= 8 && i == 2) b[flip - 4] = ~b[flip - 4];
            put(b, del && !(stop && i == 2));
        end
    endtask

    task automatic send_dllp(input bit del);
        if (del) exp_sop++;
        put(8'hF0, del);
        for (int i = 1; i < 8; i++) put(8'($urandom), del);
    endtask

    task automatic chk_totals(string tag);
        #1;
        chk({tag, " bytes"}, dcnt, exp_d);
        chk({tag, " sum"}, dsum, exp_sum);
        chk({tag, " sop"}, scnt, exp_sop);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        bit last_tlp;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk("R12 recov_req after reset", int'(recov_req), 0);
        chk("R12 err_cause after reset", int'(err_cause), 0);
        chk("R12 out_vld after reset", int'(out_vld), 0);
        send_sync(8'h00);
        chk("R12 no check before arming", int'(err_pulse), 0);
        send_sync(HDR_DATA);
        send_dllp(0);
        chk_totals("R12 no delivery before arming");

        // R5 R11: basic delivery
        pulse_eieos();
        send_sync(HDR_DATA);
        send_tlp(8, -1, 1, 0);
        send_dllp(1);
        chk_totals("R5 R11 tlp+dllp");

        // R8: end-bad after a transaction packet
        send_tlp(5, -1, 1, 0);
        send_byte(8'hC0);
        exp_null++;
        chk("R8 nullify after tlp", int'(out_nullify), 1);
        chk("R8 no error on end-bad", int'(err_pulse), 0);

        // R3: idles skipped
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
        send_dllp(1);
        chk_totals("R3 idles");

        // R7: marker, rest ignored, ordered set, fresh boundary
        send_byte(8'hE0);
        send_byte(8'h55);
        chk("R7 bytes after marker ignored", int'(err_pulse), 0);
        send_sync(HDR_OS);
        send_sync(HDR_DATA);
        send_tlp(6, -1, 1, 0);
        chk("R7 clean marker sequence", int'(recov_req), 0);
        chk_totals("R7 after marker");

        // R4 R5: maximum length
        send_tlp(1031, -1, 1, 0);
        send_dllp(1);
        chk_totals("R4 R5 max length");

        // R4: too short length
        send_tlp(4, -1, 1, 1);
        chk("R4 len 4 pulse", int'(err_pulse), 1);
        chk("R4 len 4 cause", int'(err_cause), 4);
        @(negedge clk);
        chk("R9 pulse one cycle", int'(err_pulse), 0);
        chk("R9 request held", int'(recov_req), 1);
        send_sync(8'h00);
        chk("R9 first cause kept", int'(err_cause), 4);
        send_dllp(0);
        chk_totals("R10 no delivery in error");
        pulse_eieos();
        pulse_recov();
        chk("R9 recov_done clears req", int'(recov_req), 0);
        chk("R9 recov_done clears cause", int'(err_cause), 0);
        send_sync(HDR_DATA);
        send_dllp(0);
        chk_totals("R10 lock during error ignored");

        rearm();
        send_tlp(1032, -1, 1, 1);
        chk("R4 len 1032 cause", int'(err_cause), 4);

        rearm();
        send_sync(8'h45);
        chk("R1 illegal header cause", int'(err_cause), 1);

        rearm();
        send_sync(8'h59);
        chk("R2 lane mismatch cause", int'(err_cause), 2);

        rearm();
        send_byte(8'h55);
        chk("R3 bad start cause", int'(err_cause), 3);

        rearm();
        send_dllp(1);
        send_byte(8'hC0);
        chk("R8 end-bad after dllp cause", int'(err_cause), 3);

        rearm();
        send_dllp(1);
        send_sync(HDR_OS);
        chk("R6 missing marker cause", int'(err_cause), 5);

        rearm();
        send_byte(8'hE0);
        send_sync(HDR_DATA);
        chk("R7 marker then data cause", int'(err_cause), 6);
        chk_totals("R10 R11 directed totals");

        // random well-formed stream (R5 R11 R8 R7)
        rearm();
        rnd_sync = 1;
        last_tlp = 0;
        for (int n = 0; n < 150; n++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 5) begin
                send_tlp(5 + int'($urandom % 20), -1, 1, 0); last_tlp = 1;
            end else if (r < 7) begin
                send_dllp(1); last_tlp = 0;
            end else if (r == 8 && last_tlp) begin
                send_byte(8'hC0); exp_null++; last_tlp = 0;
            end else if (r == 9) begin
                send_byte(8'hE0); send_sync(HDR_OS); send_sync(HDR_DATA); last_tlp = 0;
            end else begin
                send_byte(8'h00); last_tlp = 0;
            end
        end
        rnd_sync = 0;
        chk("R5 random stream no error", int'(recov_req), 0);
        chk_totals("R5 R11 random stream");
        #1;
        chk("R8 nullify count", ncnt, exp_null);
        @(negedge clk);

        // random single-bit header corruption (R4)
        for (int n = 0; n < 24; n++) begin
            rearm();
            send_tlp(5 + int'($urandom % 20), int'($urandom % 12), 1, 1);
            chk("R4 flipped header pulse", int'(err_pulse), 1);
            chk("R4 flipped header cause", int'(err_cause), 4);
        end
        chk_totals("R4 corrupt totals");

        finish_run();
    end
endmodule